// File: doc/BRIEF.md
# Serial clock divider-to-prescale encoder

This block turns an integer clock-divide request into the packed prescale field of a serial clock generator. The generator divides the core clock by a four-bit mantissa times a power of two, and this block picks the pair whose product is the smallest one that is still at least the request. That product gives the fastest serial clock that does not exceed the target rate. The request is the core clock frequency divided by the target rate, rounded up, and it is computed upstream.

A one-cycle start pulse loads the request. A one-cycle done pulse returns the packed field and an error flag, and both outputs stay unchanged until the next result. A parameter can place a register between the round-up stage and the renormalisation stage. This shortens the combinational path and adds one cycle of latency. Starts may arrive back to back, and each one yields its own result in order.

Top module: `sck_prescale_enc`

## Requirements
- R1: A request from 1 to 15 encodes as mantissa equal to the request and exponent 0.
- R2: A request of 0 gives the same result as a request of 1 (mantissa 1, exponent 0).
- R3: For a request of 16 or more, the mantissa lies in 8..15. The product mantissa * 2^exponent is the smallest such product that is not below the request.
- R4: When rounding the request up to the exponent granularity carries into a new leading bit, the exponent rises by one and the mantissa is renormalised. For example, request 31 gives mantissa 8 and exponent 2.
- R5: A request above 1920 needs an exponent above 7. Such a request raises err_o and forces field_o to mantissa 15, exponent 7 (0xDF). A request of exactly 1920 is accepted without error.
- R6: field_o layout: bits 3:0 hold the mantissa, bit 4 holds exponent bit 0, bit 5 is 0, and bits 7:6 hold exponent bits 2:1.
- R7: done_o pulses for one cycle, 1 cycle after the start pulse when the stage split is off and 2 cycles after it when the split is on. There is exactly one done pulse per start.
- R8: field_o and err_o do not change in any cycle in which done_o is low.
- R9: After reset, done_o, field_o and err_o are all 0.
- R10: Starts on consecutive cycles each produce their own correct result, in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that loads div_i |
| div_i | input | DIV_W | Requested integer divider |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| field_o | output | MANT_W+EXP_W+1 | Packed prescale field |
| err_o | output | 1 | Request is beyond the slowest encodable rate |

## Verification
The bench builds the block with a 16-bit request, a 4-bit mantissa and a 3-bit exponent. These widths make the 1920 boundary, the 16-bit all-ones request and the carry-out of the round-up adder reachable. It enables the stage split by default, which exercises the two-cycle path and overlapping back-to-back requests. A bench parameter switches the split off to cover the one-cycle variant. Expected fields come from a direct search over exponents 0..7 for the first ceiling quotient that fits in 15, so the reference does not rely on the leading-one arithmetic.

// File: rtl/pe_pkg.sv
package pe_pkg;
   // Bit index wide enough for any supported request width.
   typedef logic [5:0] pe_idx_t;
   localparam int PE_MAX_W = 62;
endpackage

// File: rtl/pe_lead_one.sv
module pe_lead_one #(
   parameter int W = 16
) (
   input  logic [W-1:0]    vec_i,
   output pe_pkg::pe_idx_t idx_o,
   output logic            any_o
);
   always_comb begin
      idx_o = '0;
      any_o = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (vec_i[i]) begin
            idx_o = pe_pkg::pe_idx_t'(i);
            any_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pe_round_up.sv
module pe_round_up #(
   parameter int W      = 16,
   parameter int MANT_W = 4
) (
   input  logic [W-1:0] div_i,
   output logic [W:0]   rounded_o
);
   import pe_pkg::*;

   pe_idx_t    msb;
   logic       any;
   pe_idx_t    sh;
   logic [W:0] mask;

   pe_lead_one #(.W(W)) u_lead (.vec_i(div_i), .idx_o(msb), .any_o(any));

   always_comb begin
      sh   = '0;
      mask = '0;
      if (!any || int'(msb) < MANT_W) begin
         rounded_o = {1'b0, div_i};
      end else begin
         // Keep the top MANT_W bits; round the rest up to a whole step.
         sh        = msb - pe_idx_t'(MANT_W - 1);
         mask      = ((W+1)'(1) << sh) - (W+1)'(1);
         rounded_o = ({1'b0, div_i} + mask) & ~mask;
      end
   end
endmodule

// File: rtl/pe_normalise.sv
module pe_normalise #(
   parameter int W      = 17,
   parameter int MANT_W = 4,
   parameter int EXP_W  = 3
) (
   input  logic [W-1:0]      val_i,
   output logic [MANT_W-1:0] mant_o,
   output logic [EXP_W-1:0]  exp_o,
   output logic              ovf_o
);
   import pe_pkg::*;

   localparam int EXP_MAX = (1 << EXP_W) - 1;

   pe_idx_t msb;
   logic    any;
   pe_idx_t e;

   pe_lead_one #(.W(W)) u_lead (.vec_i(val_i), .idx_o(msb), .any_o(any));

   always_comb begin
      if (!any || int'(msb) < MANT_W) e = '0;
      else                           e = msb - pe_idx_t'(MANT_W - 1);
      mant_o = MANT_W'(val_i >> e);
      exp_o  = EXP_W'(e);
      ovf_o  = int'(e) > EXP_MAX;
   end
endmodule

// File: rtl/sck_prescale_enc.sv
module sck_prescale_enc #(
   parameter  int DIV_W       = 16,
   parameter  int MANT_W      = 4,
   parameter  int EXP_W       = 3,
   parameter  bit SPLIT_ROUND = 1'b0,
   localparam int FIELD_W     = MANT_W + EXP_W + 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [DIV_W-1:0]   div_i,
   output logic               done_o,
   output logic [FIELD_W-1:0] field_o,
   output logic               err_o
);
   localparam logic [FIELD_W-1:0] MAX_FIELD =
      {{(EXP_W-1){1'b1}}, 1'b0, 1'b1, {MANT_W{1'b1}}};

   if (DIV_W <= MANT_W || DIV_W > pe_pkg::PE_MAX_W) begin : g_bad_div_w
      $error("DIV_W out of range");
   end
   if (EXP_W < 2 || EXP_W > 5 || MANT_W < 1) begin : g_bad_fmt
      $error("MANT_W/EXP_W out of range");
   end

   logic [DIV_W-1:0] div_eff;
   logic [DIV_W:0]   rnd_w;
   logic [DIV_W:0]   norm_in;
   logic             fire;
   logic [MANT_W-1:0] mant_w;
   logic [EXP_W-1:0]  exp_w;
   logic              ovf_w;

   assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;

   pe_round_up #(.W(DIV_W), .MANT_W(MANT_W)) u_round (
      .div_i(div_eff), .rounded_o(rnd_w));

   if (SPLIT_ROUND) begin : g_split
      logic [DIV_W:0] rnd_q;
      logic           vld_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rnd_q <= '0;
            vld_q <= 1'b0;
         end else begin
            vld_q <= start_i;
            if (start_i) rnd_q <= rnd_w;
         end
      end
      assign norm_in = rnd_q;
      assign fire    = vld_q;

      a_r7_done_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
         start_i |=> ##1 done_o);
      a_r7_done_src2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         done_o |-> $past(vld_q));
   end else begin : g_flat
      assign norm_in = rnd_w;
      assign fire    = start_i;

      a_r7_done_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
         start_i |=> done_o);
      a_r7_done_src1: assert property (@(posedge clk_i) disable iff (!rst_ni)
         done_o |-> $past(start_i));
   end

   pe_normalise #(.W(DIV_W+1), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_norm (
      .val_i(norm_in), .mant_o(mant_w), .exp_o(exp_w), .ovf_o(ovf_w));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         done_o  <= 1'b0;
         field_o <= '0;
         err_o   <= 1'b0;
      end else begin
         done_o <= fire;
         if (fire) begin
            err_o   <= ovf_w;
            field_o <= ovf_w ? MAX_FIELD
                             : {exp_w[EXP_W-1:1], 1'b0, exp_w[0], mant_w};
         end
      end
   end

   a_r3_normalised: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !err_o &&
       ({field_o[FIELD_W-1:MANT_W+2], field_o[MANT_W]} != '0))
      |-> field_o[MANT_W-1]);
   a_r5_err_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> field_o == MAX_FIELD);
   a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> ($stable(field_o) && $stable(err_o)));
endmodule

// File: tb/sck_prescale_enc_tb.sv
module sck_prescale_enc_tb;
   parameter bit TB_SPLIT = 1'b1;
   localparam int LAT = TB_SPLIT ? 2 : 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] div = '0;
   logic        done;
   logic [7:0]  field;
   logic        err;

   always #2.5 clk = ~clk;

   sck_prescale_enc #(.DIV_W(16), .MANT_W(4), .EXP_W(3), .SPLIT_ROUND(TB_SPLIT)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .div_i(div),
      .done_o(done), .field_o(field), .err_o(err));

   typedef struct {
      logic [7:0] f;
      logic       e;
      int         due;
      int         d;
      string      tag;
   } item_t;

   item_t q[$];
   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit finished = 1'b0;
   logic [7:0] last_f = '0;
   logic       last_e = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic void ref_enc(input int d, output logic [7:0] f, output logic e);
      int dd;
      bit found;
      dd = (d == 0) ? 1 : d;
      found = 1'b0;
      f = 8'hDF;
      e = 1'b1;
      for (int k = 0; k < 8; k++) begin
         int qq;
         qq = (dd + (1 << k) - 1) >> k;
         if (!found && qq <= 15) begin
            found = 1'b1;
            f = 8'(qq) | 8'((k & 1) << 4) | 8'(((k >> 1) & 3) << 6);
            e = 1'b0;
         end
      end
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Driver: drives one start per call and pushes the expected result.
   task automatic send(input int d, input string tag);
      item_t it;
      @(negedge clk);
      ref_enc(d, it.f, it.e);
      it.due = cyc + LAT;
      it.d   = d;
      it.tag = tag;
      q.push_back(it);
      start = 1'b1;
      div   = 16'(d);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      start = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // Monitor: compares results as they appear.
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (q.size() == 0) begin
               check(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
               item_t it;
               it = q.pop_front();
               check(cyc == it.due, "R7", $sformatf("latency d=%0d", it.d), cyc, it.due);
               check(field == it.f, it.tag, $sformatf("field d=%0d", it.d), field, it.f);
               check(err == it.e, it.tag, $sformatf("err d=%0d", it.d), err, it.e);
            end
            last_f = field;
            last_e = err;
         end else begin
            if (q.size() != 0 && q[0].due <= cyc)
               check(1'b0, "R7", "missing done", 0, 1);
            if (field != last_f || err != last_e)
               check(1'b0, "R8", "output moved without done", field, last_f);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R9", "reset done", done, 0);
      check(field == 8'h00, "R9", "reset field", field, 0);
      check(err == 1'b0, "R9", "reset err", err, 0);
      rst_n = 1'b1;
      idle(2);

      send(0, "R2");     idle(3);
      send(1, "R1");     idle(3);
      send(7, "R1");     idle(3);
      send(15, "R1");    idle(3);
      send(16, "R3");    idle(3);
      check(field == 8'h18, "R6", "layout 16", field, 8'h18);
      send(17, "R3");    idle(3);
      send(30, "R3");    idle(3);
      send(31, "R4");    idle(3);
      check(field == 8'h48, "R4", "carry 31", field, 8'h48);
      send(63, "R4");    idle(3);
      check(field == 8'h58, "R6", "layout 63", field, 8'h58);
      send(100, "R3");   idle(3);
      send(1000, "R3");  idle(3);
      send(1919, "R4");  idle(3);
      send(1920, "R5");  idle(3);
      check(field == 8'hDF && err == 1'b0, "R5", "boundary 1920", {err, field}, 9'h0DF);
      send(1921, "R5");  idle(3);
      check(err == 1'b1, "R5", "error 1921", err, 1);
      send(2047, "R5");  idle(3);
      send(65535, "R5"); idle(3);
      send(15, "R1");    idle(8);  // hold window for R8 after an error result

      // R10: back-to-back starts
      send(5, "R10");
      send(33, "R10");
      send(3000, "R10");
      send(47, "R10");
      send(0, "R10");
      idle(4);
      for (int d = 3; d < 2200; d += 41) send(d, "R10");
      idle(6);

      check(q.size() == 0, "R7", "results outstanding", q.size(), 0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule